// File: doc/BRIEF.md
# Display Host Register Interface

This block is the processor-facing storage of an eight-digit dot-matrix display controller. A parallel bus carries the requests. It has an active-low chip select, separate active-low write and read strobes, a flash-select line, two mode bits, a three-bit address and an eight-bit data path. These pick one of five storage regions:
- a character store with one byte per digit
- a per-digit flash flag store
- a four-bit glyph pointer
- a glyph pattern store holding sixteen custom characters of seven five-dot rows
- a control word

The glyph pattern store is addressed indirectly. The pointer names the glyph, and the bus address names the row.

The bus pins are registered on the system clock. A write commits on the clock edge where the write strobe is seen high after being low with chip select low. Reset and the clear command in the control word wipe the character and flash stores over a fixed number of clocks. During that time a busy flag is raised and host writes are dropped. A read-only scan port gives the display refresh logic the character byte, the flash flag and one glyph row. Control bit 5 is not written by the host: it carries the self-test result supplied from outside.

Top module: `disp_host_regs`

## Requirements
- R1: Region decode: `flash_n`=0 selects the flash store whatever `mode` is. With `flash_n`=1, `mode`=00 selects the glyph pointer, 01 the glyph pattern store, 11 the character store, and 10 the control word.
- R2: The character store keeps all eight bits written to each digit (digit 0 is address 0). A byte with bit 7 low holds a 7-bit code in bits 6..0. A byte with bit 7 high holds a glyph index in bits 3..0.
- R3: The glyph pointer stores data bits 3..0, and bits 7..4 are dropped. It reads back as `{4'b0, ptr}`.
- R4: A glyph pattern write stores data bits 4..0 in the row given by `addr` of the glyph selected by the pointer. A 1 bit is a lit dot. Row 7 does not exist: writes to it are dropped and reads of it return zero.
- R5: The flash store keeps only data bit 0 per digit (1 means flashing). It reads back as `{7'b0, flag}`.
- R6: A write commits only on a low-to-high transition of `wr_n` while `cs_n` is low. Holding `wr_n` low changes nothing, and strobing with `cs_n` high changes nothing.
- R7: While `rst` is high, every character becomes 0x20, every flash flag 0 and the control word 0. `busy` is high during reset and for the next CLR_CYCLES-1 clock edges after it is released: sampled after the 1st and 2nd edges it is 1, after the 3rd it is 0.
- R8: Writing the control word with bit 7 set raises `busy` for CLR_CYCLES edges. The characters are set to 0x20 and the flash flags to 0. The other written control bits are kept, and bit 7 reads 0 once `busy` falls.
- R9: A write whose commit edge falls while `busy` is high has no effect.
- R10: Control bit 5 on reads and on `ctrl_word` follows `selftest_pass`, as registered one clock earlier. The value written to bit 5 is ignored.
- R11: Read data appears one clock after `cs_n` and `rd_n` are sampled low. `rdata_oe` is high only in that case. Bit positions a region does not use read as zero, and `rdata` is zero while `rdata_oe` is low.
- R12: The scan port returns the character byte and flash flag of `scan_digit`, and the dots of row `scan_row` of glyph `scan_glyph`, one clock after the address is applied. Row 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, commits on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| flash_n | input | 1 | Low selects the flash flag store |
| mode | input | 2 | Region select bits |
| addr | input | 3 | Digit or glyph row address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data bus enable |
| busy | output | 1 | Reset or clear in progress; writes dropped |
| selftest_pass | input | 1 | Self-test result shown as control bit 5 |
| ctrl_word | output | 8 | Current control word |
| scan_digit | input | 3 | Refresh digit address |
| scan_glyph | input | 4 | Refresh glyph index |
| scan_row | input | 3 | Refresh glyph row |
| scan_char | output | 8 | Character byte of scan_digit |
| scan_flash | output | 1 | Flash flag of scan_digit |
| scan_dots | output | 5 | Dot row of the scanned glyph |

## Verification
The assertions take for granted that the host does not start a write while `busy` is high if it cares about the result. They also assume that chip select, mode and address stay still while a strobe is low, so that the registered copy of the bus seen at the commit edge is the one the host meant. Every bench transaction changes its inputs only on falling clock edges and holds them for at least one full clock per strobe phase. The bench makes writes during busy on purpose, and in those cases it only checks that the stores stay as they were.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] BLANK = 8'h20;

  typedef enum logic [2:0] {
    RG_NONE, RG_FLAG, RG_PTR, RG_GLYPH, RG_CHAR, RG_CTRL
  } region_e;

  typedef struct packed {
    logic chr;
    logic flg;
    logic ptr;
    logic gly;
    logic ctl;
  } wen_t;

  function automatic region_e region_of(input logic flash_n, input logic [1:0] mode);
    region_e r;
    if (!flash_n) r = RG_FLAG;
    else begin
      case (mode)
        2'b00:   r = RG_PTR;
        2'b01:   r = RG_GLYPH;
        2'b11:   r = RG_CHAR;
        default: r = RG_CTRL;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/dhr_bus_sync.sv
module dhr_bus_sync
  import dhr_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          flash_n,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output wen_t          wen,
  output logic [AW-1:0] wa,
  output logic [DW-1:0] wd
);
  logic          cs_q, wr_q, fl_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          commit;
  region_e       reg_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      wr_q   <= 1'b1;
      fl_q   <= 1'b1;
      mode_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cs_q   <= cs_n;
      wr_q   <= wr_n;
      fl_q   <= flash_n;
      mode_q <= mode;
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  assign commit  = !rst && !cs_q && !wr_q && wr_n && !busy;
  assign reg_sel = region_of(fl_q, mode_q);

  always_comb begin
    wen     = '0;
    wen.chr = commit && (reg_sel == RG_CHAR);
    wen.flg = commit && (reg_sel == RG_FLAG);
    wen.ptr = commit && (reg_sel == RG_PTR);
    wen.gly = commit && (reg_sel == RG_GLYPH);
    wen.ctl = commit && (reg_sel == RG_CTRL);
  end

  assign wa = addr_q;
  assign wd = data_q;
endmodule

// File: rtl/dhr_ctrl_regs.sv
module dhr_ctrl_regs
  import dhr_pkg::*;
#(
  parameter int GW         = 4,
  parameter int CLR_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_we,
  input  logic          ctl_we,
  input  logic [DW-1:0] wd,
  input  logic          selftest_pass,
  output logic [GW-1:0] ptr,
  output logic [DW-1:0] ctrl_word,
  output logic          busy,
  output logic          clr
);
  localparam int CW = $clog2(CLR_CYCLES + 1);
  localparam logic [CW-1:0] CLR_LOAD = CW'(CLR_CYCLES);

  logic [DW-1:0] ctrl_q;
  logic [CW-1:0] cnt_q;
  logic          st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ptr    <= '0;
      cnt_q  <= CLR_LOAD;
      st_q   <= 1'b0;
    end else begin
      st_q <= selftest_pass;
      if (ptr_we) ptr <= wd[GW-1:0];
      if (ctl_we) begin
        ctrl_q <= {wd[7:6], 1'b0, wd[4:0]};
        if (wd[7]) cnt_q <= CLR_LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) ctrl_q[7] <= 1'b0;
      end
    end
  end

  assign busy      = (cnt_q != '0);
  assign clr       = rst || busy;
  assign ctrl_word = {ctrl_q[7:6], st_q, ctrl_q[4:0]};

  // R8: the clear request bit is gone once busy drops
  assert_clear_ends_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !ctrl_word[7]);

  // R10: bit 5 mirrors the result input of the previous clock
  assert_selftest_bit_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ctrl_word[5] == $past(selftest_pass));
endmodule

// File: rtl/dhr_char_store.sv
module dhr_char_store
  import dhr_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          busy,
  input  logic          chr_we,
  input  logic          flg_we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_char,
  output logic          rd_flag,
  input  logic [AW-1:0] scan_digit,
  output logic [DW-1:0] scan_char,
  output logic          scan_flash
);
  logic [DW-1:0]     chars [DIGITS];
  logic [DIGITS-1:0] flags;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    always_ff @(posedge clk) begin
      if (clr) begin
        chars[i] <= BLANK;
        flags[i] <= 1'b0;
      end else begin
        if (chr_we && wa == AW'(i)) chars[i] <= wd;
        if (flg_we && wa == AW'(i)) flags[i] <= wd[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    rd_char    <= chars[rd_addr];
    rd_flag    <= flags[rd_addr];
    scan_char  <= chars[scan_digit];
    scan_flash <= flags[scan_digit];
  end

  // R9: no store update can be requested while the clear sequence runs
  assert_no_write_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(chr_we || flg_we));

  // R8: when the clear window closes the flash flags are all zero
  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(clr) |-> (flags == '0 && chars[0] == BLANK));
endmodule

// File: rtl/dhr_glyph_ram.sv
module dhr_glyph_ram #(
  parameter int GLYPHS = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int AW     = 3,
  parameter int GW     = 4
) (
  input  logic            clk,
  input  logic            we,
  input  logic [GW-1:0]   wptr,
  input  logic [AW-1:0]   wrow,
  input  logic [COLS-1:0] wdots,
  input  logic [GW-1:0]   rptr,
  input  logic [AW-1:0]   rrow,
  output logic [COLS-1:0] rdots,
  input  logic [GW-1:0]   sptr,
  input  logic [AW-1:0]   srow,
  output logic [COLS-1:0] sdots
);
  localparam int DEPTH = GLYPHS << AW;
  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

  logic [COLS-1:0] mem [DEPTH];
  logic [COLS-1:0] rq, sq;
  logic            rv_q, sv_q;

  always_ff @(posedge clk) begin
    if (we && wrow <= LAST_ROW) mem[{wptr, wrow}] <= wdots;
  end

  always_ff @(posedge clk) begin
    rq   <= mem[{rptr, rrow}];
    rv_q <= (rrow <= LAST_ROW);
  end

  always_ff @(posedge clk) begin
    sq   <= mem[{sptr, srow}];
    sv_q <= (srow <= LAST_ROW);
  end

  assign rdots = rv_q ? rq : '0;
  assign sdots = sv_q ? sq : '0;
endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
  import dhr_pkg::*;
#(
  parameter int DIGITS     = 8,
  parameter int GLYPHS     = 16,
  parameter int ROWS       = 7,
  parameter int COLS       = 5,
  parameter int CLR_CYCLES = 3,
  localparam int AW        = $clog2(DIGITS),
  localparam int GW        = $clog2(GLYPHS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic            flash_n,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            rdata_oe,
  output logic            busy,
  input  logic            selftest_pass,
  output logic [7:0]      ctrl_word,
  input  logic [AW-1:0]   scan_digit,
  input  logic [GW-1:0]   scan_glyph,
  input  logic [AW-1:0]   scan_row,
  output logic [7:0]      scan_char,
  output logic            scan_flash,
  output logic [COLS-1:0] scan_dots
);
  wen_t            wen;
  logic [AW-1:0]   wa;
  logic [DW-1:0]   wd;
  logic [GW-1:0]   ptr;
  logic            clr;
  logic [DW-1:0]   rd_char;
  logic            rd_flag;
  logic [COLS-1:0] rd_dots;
  region_e         rd_reg_q;
  logic [DW-1:0]   ctrl_snap_q;
  logic [GW-1:0]   ptr_snap_q;
  logic [DW-1:0]   rd_mux;

  dhr_bus_sync #(.AW(AW)) u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .flash_n(flash_n),
    .mode(mode), .addr(addr), .wdata(wdata), .busy(busy),
    .wen(wen), .wa(wa), .wd(wd)
  );

  dhr_ctrl_regs #(.GW(GW), .CLR_CYCLES(CLR_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .ptr_we(wen.ptr), .ctl_we(wen.ctl), .wd(wd),
    .selftest_pass(selftest_pass), .ptr(ptr), .ctrl_word(ctrl_word),
    .busy(busy), .clr(clr)
  );

  dhr_char_store #(.DIGITS(DIGITS), .AW(AW)) u_chars (
    .clk(clk), .rst(rst), .clr(clr), .busy(busy),
    .chr_we(wen.chr), .flg_we(wen.flg), .wa(wa), .wd(wd),
    .rd_addr(addr), .rd_char(rd_char), .rd_flag(rd_flag),
    .scan_digit(scan_digit), .scan_char(scan_char), .scan_flash(scan_flash)
  );

  dhr_glyph_ram #(.GLYPHS(GLYPHS), .ROWS(ROWS), .COLS(COLS), .AW(AW), .GW(GW)) u_glyph (
    .clk(clk), .we(wen.gly), .wptr(ptr), .wrow(wa), .wdots(wd[COLS-1:0]),
    .rptr(ptr), .rrow(addr), .rdots(rd_dots),
    .sptr(scan_glyph), .srow(scan_row), .sdots(scan_dots)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg_q    <= RG_NONE;
      rdata_oe    <= 1'b0;
      ctrl_snap_q <= '0;
      ptr_snap_q  <= '0;
    end else begin
      rd_reg_q    <= (!cs_n && !rd_n) ? region_of(flash_n, mode) : RG_NONE;
      rdata_oe    <= !cs_n && !rd_n;
      ctrl_snap_q <= ctrl_word;
      ptr_snap_q  <= ptr;
    end
  end

  always_comb begin
    case (rd_reg_q)
      RG_FLAG:  rd_mux = {{(DW-1){1'b0}}, rd_flag};
      RG_PTR:   rd_mux = {{(DW-GW){1'b0}}, ptr_snap_q};
      RG_GLYPH: rd_mux = {{(DW-COLS){1'b0}}, rd_dots};
      RG_CHAR:  rd_mux = rd_char;
      RG_CTRL:  rd_mux = ctrl_snap_q;
      default:  rd_mux = '0;
    endcase
  end

  assign rdata = rdata_oe ? rd_mux : '0;

  // R11: the bus is driven only after a sampled chip-select plus read
  assert_oe_gate_R11: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n || rd_n) |-> !rdata_oe);

  // R1: at most one region accepts any committed write
  assert_one_region_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wen));

  // R9: a busy cycle never carries a write enable into the stores
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> wen == '0);
endmodule

// File: tb/tb_disp_host_regs.sv
`timescale 1ns/1ps
module tb_disp_host_regs;
  logic clk = 1'b0;
  logic rst, cs_n, wr_n, rd_n, flash_n, rdata_oe, busy, selftest_pass, scan_flash;
  logic [1:0] mode;
  logic [2:0] addr, scan_digit, scan_row;
  logic [3:0] scan_glyph;
  logic [7:0] wdata, rdata, ctrl_word, scan_char;
  logic [4:0] scan_dots;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  disp_host_regs dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .flash_n(flash_n),
    .mode(mode), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .busy(busy), .selftest_pass(selftest_pass), .ctrl_word(ctrl_word),
    .scan_digit(scan_digit), .scan_glyph(scan_glyph), .scan_row(scan_row),
    .scan_char(scan_char), .scan_flash(scan_flash), .scan_dots(scan_dots)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic fl, input logic [1:0] md, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; flash_n = fl; mode = md; addr = a; wdata = d;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic hread(input logic fl, input logic [1:0] md, input logic [2:0] a,
                       output logic [7:0] v, output logic oe);
    @(negedge clk); cs_n = 0; rd_n = 0; flash_n = fl; mode = md; addr = a;
    @(negedge clk); v = rdata; oe = rdata_oe; cs_n = 1; rd_n = 1;
  endtask

  function automatic logic [4:0] pat(input int g, input int r);
    return 5'((g * 7 + r * 3 + 1) & 31);
  endfunction

  initial begin
    logic [7:0] v;
    logic oe;
    rst = 1; cs_n = 1; wr_n = 1; rd_n = 1; flash_n = 1; mode = 0; addr = 0; wdata = 0;
    selftest_pass = 0; scan_digit = 0; scan_glyph = 0; scan_row = 0;
    repeat (3) @(negedge clk);
    chk("R7 busy during reset", busy, 1);
    rst = 0;
    // R9: commit edge lands inside the post-reset busy window
    hwrite(1, 2'b11, 3'd0, 8'h41);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hread(1, 2'b11, 3'(i), v, oe);
      chk($sformatf("R7 R9 char %0d blank after reset", i), v, 8'h20);
      hread(0, 2'b10, 3'(i), v, oe);
      chk($sformatf("R7 flash %0d clear", i), v, 0);
    end
    hread(1, 2'b10, 3'd0, v, oe);
    chk("R7 ctrl zero", v, 0);
    chk("R11 oe during read", oe, 1);
    @(negedge clk);
    chk("R11 oe idle", rdata_oe, 0);
    chk("R11 rdata idle zero", rdata, 0);

    // R2 character store, both byte formats
    for (int i = 0; i < 8; i++)
      hwrite(1, 2'b11, 3'(i), (i < 4) ? 8'(8'h30 + i * 5) : 8'(8'h80 | i));
    for (int i = 0; i < 8; i++) begin
      hread(1, 2'b11, 3'(i), v, oe);
      chk($sformatf("R2 char %0d", i), v, (i < 4) ? (8'h30 + i * 5) : (8'h80 | i));
      scan_digit = 3'(i);
      @(negedge clk);
      chk($sformatf("R12 scan char %0d", i), scan_char, (i < 4) ? (8'h30 + i * 5) : (8'h80 | i));
    end

    // R5 flash store, R1 mode bits ignored when flash_n low
    for (int i = 0; i < 8; i++)
      hwrite(0, 2'(i), 3'(i), 8'(((i % 3) == 0) ? 8'hA5 : 8'h5A));
    for (int i = 0; i < 8; i++) begin
      hread(0, 2'(i + 1), 3'(i), v, oe);
      chk($sformatf("R5 R11 flash %0d", i), v, ((i % 3) == 0) ? 1 : 0);
      scan_digit = 3'(i);
      @(negedge clk);
      chk($sformatf("R12 scan flash %0d", i), scan_flash, ((i % 3) == 0) ? 1 : 0);
    end
    hread(1, 2'b11, 3'd0, v, oe);
    chk("R1 flash writes left char intact", v, 8'h30);

    // R3 glyph pointer
    for (int p = 0; p < 16; p++) begin
      hwrite(1, 2'b00, 3'd5, 8'({4'(~p), 4'(p)}));
      hread(1, 2'b00, 3'd0, v, oe);
      chk($sformatf("R3 pointer %0d", p), v, p);
    end

    // R4 glyph pattern store
    for (int g = 0; g < 16; g++) begin
      hwrite(1, 2'b00, 3'd0, 8'(g));
      for (int r = 0; r < 7; r++) hwrite(1, 2'b01, 3'(r), {3'b111, pat(g, r)});
      hwrite(1, 2'b01, 3'd7, 8'hFF);
    end
    for (int g = 0; g < 16; g++) begin
      hwrite(1, 2'b00, 3'd0, 8'(g));
      for (int r = 0; r < 8; r++) begin
        hread(1, 2'b01, 3'(r), v, oe);
        chk($sformatf("R4 glyph %0d row %0d", g, r), v, (r < 7) ? int'(pat(g, r)) : 0);
        scan_glyph = 4'(g); scan_row = 3'(r);
        @(negedge clk);
        chk($sformatf("R12 scan glyph %0d row %0d", g, r), scan_dots, (r < 7) ? int'(pat(g, r)) : 0);
      end
    end

    // R6 no commit while strobe held low, none with chip select high
    scan_digit = 3'd3;
    @(negedge clk); cs_n = 0; wr_n = 0; flash_n = 1; mode = 2'b11; addr = 3'd3; wdata = 8'h77;
    @(negedge clk);
    @(negedge clk);
    chk("R6 strobe low no change", scan_char, 8'h3F);
    wr_n = 1;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    chk("R6 rising edge commits", scan_char, 8'h77);
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 3'd3; wdata = 8'h11;
    @(negedge clk); wr_n = 1;
    repeat (2) @(negedge clk);
    chk("R6 chip select high ignored", scan_char, 8'h77);

    // R10 read-only result bit
    selftest_pass = 1;
    hwrite(1, 2'b10, 3'd0, 8'h00);
    hread(1, 2'b10, 3'd0, v, oe);
    chk("R10 bit5 follows pass", v, 8'h20);
    selftest_pass = 0;
    hwrite(1, 2'b10, 3'd0, 8'h7F);
    hread(1, 2'b10, 3'd0, v, oe);
    chk("R10 bit5 write ignored", v, 8'h5F);
    chk("R10 ctrl_word port", ctrl_word, 8'h5F);

    // R8 clear command
    hwrite(1, 2'b10, 3'd0, 8'h8B);
    chk("R8 busy edge 0", busy, 1);
    @(negedge clk); chk("R8 busy edge 1", busy, 1);
    @(negedge clk); chk("R8 busy edge 2", busy, 1);
    @(negedge clk); chk("R8 busy released", busy, 0);
    hread(1, 2'b10, 3'd0, v, oe);
    chk("R8 ctrl keeps low bits", v, 8'h0B);
    for (int i = 0; i < 8; i++) begin
      scan_digit = 3'(i);
      @(negedge clk);
      chk($sformatf("R8 char %0d cleared", i), scan_char, 8'h20);
      chk($sformatf("R8 flash %0d cleared", i), scan_flash, 0);
    end

    // R9 write during clear dropped
    hwrite(1, 2'b11, 3'd2, 8'h44);
    hwrite(1, 2'b10, 3'd0, 8'h80);
    hwrite(1, 2'b11, 3'd2, 8'h55);
    repeat (3) @(negedge clk);
    hread(1, 2'b11, 3'd2, v, oe);
    chk("R9 write during clear dropped", v, 8'h20);

    // R7 reset wipes stored content and busy window length
    hwrite(1, 2'b11, 3'd6, 8'h66);
    hwrite(0, 2'b00, 3'd6, 8'h01);
    hwrite(1, 2'b10, 3'd0, 8'h1C);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk); chk("R7 busy after edge 1", busy, 1);
    @(negedge clk); chk("R7 busy after edge 2", busy, 1);
    @(negedge clk); chk("R7 busy after edge 3", busy, 0);
    hread(1, 2'b11, 3'd6, v, oe);
    chk("R7 char reset", v, 8'h20);
    hread(0, 2'b00, 3'd6, v, oe);
    chk("R7 flash reset", v, 0);
    hread(1, 2'b10, 3'd0, v, oe);
    chk("R7 ctrl reset", v, 0);

    finish_run();
  end
endmodule